// File: doc/BRIEF.md
# Hit Input to Histogram Crosspoint

This block lets software choose, for each of sixteen histogram engines, which of sixteen hit input channels feeds it. Every histogram output owns a select register holding an input channel index, so any input can drive any histogram and one input can drive several histograms at once. The routed hit pulses are registered, so every output trails its selected input by exactly one clock.

Software reaches the select registers and two read-only size registers through a single-cycle 16-bit register port. A read request returns data one clock later on `reg_rdata_o`, which holds its value until the next read. Select registers occupy word offsets 0xC0 to 0xCF, one per histogram in ascending order. Offset 0x0D reports the number of inputs and 0x0E the number of histogram engines.

Top module: `hist_xpoint`

## Requirements
- R1: After reset every `hist_hit_o` bit is 0 and the select register for histogram n holds n.
- R2: `hist_hit_o[n]` equals, one clock later, the value of `hit_i[k]`, where k is the select value of histogram n in effect at that clock.
- R3: One input selected by several histograms drives all of them in the same cycle.
- R4: A write to offset 0xC0+n stores bits [3:0] of `reg_wdata_i` as the select of histogram n. Bits [15:4] are discarded and read back as zero.
- R5: A read (`reg_cs_i`=1, `reg_we_i`=0) places the addressed word on `reg_rdata_o` one clock later. `reg_rdata_o` keeps its value in every cycle without a read.
- R6: A read of offset 0x0D returns 16 (inputs) and a read of offset 0x0E returns 16 (histogram engines). Writes to these offsets change nothing.
- R7: A hit presented in the same cycle as a select write is routed through the old select. The new select applies from the next cycle, with no extra pulse on the output.
- R8: A write to an offset outside 0xC0–0xCF changes no select register. A read of an offset that is neither a select nor a size register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 16 | Hit pulses from the input channels |
| reg_cs_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register word offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid one clock after a read |
| hist_hit_o | output | 16 | Routed hit pulses, one per histogram engine |

## Verification
A select write and the routing of a hit through the same select can land on the same clock edge. The bench provokes this in two ways. A directed case rewrites histogram 0's select while pulsing only its old input. A random phase overlaps writes with dense random hit traffic. A behavioural model applies each write after routing that cycle's hits. The bench compares its output against the design's every cycle, so an early switch or a spurious pulse during the switch shows up as a mismatch.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 16;

  typedef struct packed {
    logic              cs;
    logic              we;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] wdata;
  } reg_req_t;
endpackage

// File: rtl/xp_sel_regs.sv
module xp_sel_regs
  import xp_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 16,
  parameter int SEL_BASE  = 'hC0,
  parameter int NIN_ADDR  = 'h0D,
  parameter int NOUT_ADDR = 'h0E,
  localparam int SEL_W    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  reg_req_t                    req_i,
  output logic [REG_DW-1:0]           rdata_o,
  output logic [N_OUT-1:0][SEL_W-1:0] sel_o
);
  localparam logic [REG_AW-1:0] NIN_A  = REG_AW'(NIN_ADDR);
  localparam logic [REG_AW-1:0] NOUT_A = REG_AW'(NOUT_ADDR);

  logic                        wr, rd;
  logic [N_OUT-1:0]            sel_hit;
  logic [N_OUT-1:0][SEL_W-1:0] sel_q;
  logic [REG_DW-1:0]           rd_val;

  assign wr = req_i.cs & req_i.we;
  assign rd = req_i.cs & ~req_i.we;

  for (genvar n = 0; n < N_OUT; n++) begin : g_dec
    localparam logic [REG_AW-1:0] SEL_A = REG_AW'(SEL_BASE + n);
    assign sel_hit[n] = (req_i.addr == SEL_A);

    AST_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && req_i.addr == SEL_A) |=> sel_q[n] == $past(req_i.wdata[SEL_W-1:0])); // R4
    AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr && req_i.addr == SEL_A) |=> $stable(sel_q[n])); // R8
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < N_OUT; n++) sel_q[n] <= SEL_W'(n % N_IN);
    end else if (wr) begin
      for (int n = 0; n < N_OUT; n++)
        if (sel_hit[n]) sel_q[n] <= req_i.wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int n = 0; n < N_OUT; n++)
      if (sel_hit[n]) rd_val = REG_DW'(sel_q[n]);
    if (req_i.addr == NIN_A)  rd_val = REG_DW'(N_IN);
    if (req_i.addr == NOUT_A) rd_val = REG_DW'(N_OUT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end

  assign sel_o = sel_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o)); // R5
  AST_RO_NIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && req_i.addr == NIN_A) |=> rdata_o == REG_DW'(N_IN)); // R6
  AST_RO_NOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && req_i.addr == NOUT_A) |=> rdata_o == REG_DW'(N_OUT)); // R6
endmodule

// File: rtl/xp_route.sv
module xp_route #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 16,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_IN-1:0]             hit_i,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0]            hit_o
);
  logic [N_OUT-1:0] mux_d;

  for (genvar n = 0; n < N_OUT; n++) begin : g_mux
    assign mux_d[n] = hit_i[sel_i[n]];
  end

  // single flop stage after the mux: glitch-free switch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= '0;
    else         hit_o <= mux_d;
  end

  AST_NO_SRC_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit_i) |=> hit_o == '0); // R2
  AST_ALL_SRC_ALL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hit_i) |=> (&hit_o)); // R3
endmodule

// File: rtl/hist_xpoint.sv
module hist_xpoint
  import xp_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 16,
  parameter int SEL_BASE  = 'hC0,
  parameter int NIN_ADDR  = 'h0D,
  parameter int NOUT_ADDR = 'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   hit_i,
  input  logic              reg_cs_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic [N_OUT-1:0]  hist_hit_o
);
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  reg_req_t                    req;
  logic [N_OUT-1:0][SEL_W-1:0] sel;

  assign req = '{cs: reg_cs_i, we: reg_we_i, addr: reg_addr_i, wdata: reg_wdata_i};

  xp_sel_regs #(
    .N_IN(N_IN), .N_OUT(N_OUT), .SEL_BASE(SEL_BASE),
    .NIN_ADDR(NIN_ADDR), .NOUT_ADDR(NOUT_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req),
    .rdata_o(reg_rdata_o), .sel_o(sel)
  );

  xp_route #(.N_IN(N_IN), .N_OUT(N_OUT)) u_route (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i),
    .sel_i(sel), .hit_o(hist_hit_o)
  );
endmodule

// File: tb/tb_hist_xpoint.sv
module tb_hist_xpoint;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] hit = '0;
  logic        cs = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] hist;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  hist_xpoint dut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .reg_cs_i(cs), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hist_hit_o(hist)
  );

  // behavioural reference
  int          sel_m[16];
  logic [15:0] exp_hist, exp_rd;

  function automatic logic [15:0] rd_model(input logic [7:0] a);
    if (a >= 8'hC0 && a <= 8'hCF) return 16'(sel_m[a - 8'hC0]);
    if (a == 8'h0D) return 16'd16;
    if (a == 8'h0E) return 16'd16;
    return 16'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 16; n++) sel_m[n] = n;
      exp_hist = '0;
      exp_rd   = '0;
    end else begin
      logic [15:0] nh;
      for (int n = 0; n < 16; n++) nh[n] = hit[sel_m[n]];
      if (cs && !we) exp_rd = rd_model(addr);
      if (cs && we && addr >= 8'hC0 && addr <= 8'hCF) sel_m[addr - 8'hC0] = int'(wdata[3:0]);
      exp_hist = nh;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, "/R2 hist"}, hist, exp_hist);
    chk({cur_req, "/R5 rdata"}, rdata, exp_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); cs = 0; #0.1 d = rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hist after reset", hist, 16'h0000);
    chk("R1 rdata after reset", rdata, 16'h0000);
    rst_n = 1;
    for (int n = 0; n < 16; n++) begin
      rd(8'(8'hC0 + n), d);
      chk("R1 select default", d, 16'(n));
    end
    // R2: identity routing, walking hit
    cur_req = "R2";
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); hit = 16'(1 << k);
      @(negedge clk); hit = '0;
      #0.1 chk("R2 identity walk", hist, 16'(1 << k));
    end
    // R6: size registers, write ignored
    cur_req = "R6";
    rd(8'h0D, d); chk("R6 input count", d, 16'd16);
    rd(8'h0E, d); chk("R6 histogram count", d, 16'd16);
    wr(8'h0D, 16'h0003); wr(8'h0E, 16'h0001);
    rd(8'h0D, d); chk("R6 input count after write", d, 16'd16);
    rd(8'h0E, d); chk("R6 histogram count after write", d, 16'd16);
    // R4: upper bits discarded
    cur_req = "R4";
    wr(8'hC2, 16'hFFF3);
    rd(8'hC2, d); chk("R4 readback masked", d, 16'h0003);
    // R8: unmapped writes/reads
    cur_req = "R8";
    wr(8'h10, 16'h0005); wr(8'hBF, 16'h0007); wr(8'hD0, 16'h0009);
    rd(8'hD0, d); chk("R8 unmapped read", d, 16'h0000);
    rd(8'h10, d); chk("R8 unmapped read", d, 16'h0000);
    rd(8'hC0, d); chk("R8 sel0 untouched", d, 16'h0000);
    rd(8'hCF, d); chk("R8 sel15 untouched", d, 16'h000F);
    // R3: fan-out of input 4 to histograms 3, 7, 9
    cur_req = "R3";
    wr(8'hC3, 16'h0004); wr(8'hC7, 16'h0004); wr(8'hC9, 16'h0004);
    @(negedge clk); hit = 16'h0010;
    @(negedge clk); hit = '0;
    #0.1 chk("R3 fan-out", hist, 16'h0298);
    // R7: write and hit in the same cycle
    cur_req = "R7";
    @(negedge clk); cs = 1; we = 1; addr = 8'hC0; wdata = 16'h0006; hit = 16'h0001;
    @(negedge clk); cs = 0; we = 0; hit = 16'h0040;
    #0.1 chk("R7 old select on write cycle", 16'(hist[0]), 16'h0001);
    @(negedge clk); hit = 16'h0001;
    #0.1 chk("R7 new select next cycle", 16'(hist[0]), 16'h0001);
    @(negedge clk); hit = '0;
    #0.1 chk("R7 old input no longer routed", 16'(hist[0]), 16'h0000);
    // R5: rdata holds with no read
    cur_req = "R5";
    rd(8'hC0, d); chk("R5 read value", d, 16'h0006);
    wr(8'hC0, 16'h0002);
    repeat (3) @(negedge clk);
    #0.1 chk("R5 rdata held", rdata, 16'h0006);
    // random overlap of writes, reads and hits
    cur_req = "R7rand";
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      hit = 16'($urandom);
      cs = ($urandom % 3) == 0;
      we = $urandom % 2;
      addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'(8'hC0 + ($urandom % 16));
      wdata = 16'($urandom);
    end
    @(negedge clk); cs = 0; hit = '0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule